// File: doc/BRIEF.md
# Multichannel Crossing-Synchronous Fine-Time Digitizer

This block measures, for each of its detector channels, where inside a beam crossing the first discriminator hit arrived. A fast clock, phase-locked to the crossing clock at an integer multiple of it, advances one shared fine-time count. A rising edge on the crossing strobe restarts that count at bin 0. The first rising hit edge on a channel freezes the count for that channel. The crossing is divided into 64 bins, so each result is a 6-bit fine time. Hit inputs are already synchronous to the fast clock.

When the next crossing strobe arrives, the results of the crossing just closed are captured into a readout bank. They leave as 32-bit words over a valid/ready stream, in ascending channel order. Each word carries the crossing number, the channel number, a valid flag and the fine time. Normally only channels that saw a hit are sent. A mode input makes every channel report, with empty channels flagged invalid.

An internal test-pulse source can inject one pulse per crossing, at a programmable bin, into any set of channels. Stepping that bin lets a channel-alive scan check that the reported time follows the setting.

Top module: `tdc_array`

## Requirements
- R1: If the strobe rise is sampled at clock edge E0, a hit whose rising edge is first sampled at edge Ej (j at least 1) reports fine time j-1.
- R2: All 32 channels measure independently. A hit on one channel does not change another channel's result.
- R3: Only the first rising hit edge of a crossing is kept. Later edges in the same crossing are ignored, and a hit held high counts once.
- R4: Each output word has the crossing number in bits 31:24, the channel in bits 20:16, the valid flag in bit 15 and the fine time in bits 5:0. Bits 23:21 and 14:6 are zero, and after reset out_data is zero.
- R5: A crossing's words become available in the cycle after the edge that samples the next strobe rise. They are sent in ascending channel order. With emit_empty low, only channels that saw a hit are sent, and out_valid falls once all have been taken.
- R6: While out_valid is high and out_ready is low, out_valid and out_data hold unchanged until a new crossing closes.
- R7: If emit_empty is high at the closing strobe edge, every channel is sent. A channel without a hit reports valid 0 and fine time 63 (all ones).
- R8: The first strobe after reset opens crossing 0 and sends no words, even with emit_empty high. Each later strobe adds one to the crossing number, modulo 256.
- R9: With tp_enable high, the channels set in tp_mask receive one pulse in the cycle where the fine count equals tp_offset. Those channels report tp_offset unless an external hit arrived earlier in the crossing.
- R10: A hit edge sampled at the same edge as the strobe rise is ignored. If the channel stays high afterwards, it produces no word. Closing a new crossing discards any words not yet taken.
- R11: The fine count stops at 63. A hit arriving after bin 63 of a long crossing reports 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast digitizing clock |
| rst | input | 1 | Synchronous active-high reset |
| bx_strobe | input | 1 | Crossing strobe; a rising edge starts a crossing |
| hit_in | input | 32 | Synchronised discriminator hits, one per channel |
| emit_empty | input | 1 | Report every channel, including channels without a hit |
| tp_enable | input | 1 | Enables the internal test pulse |
| tp_mask | input | 32 | Channels that receive the test pulse |
| tp_offset | input | 6 | Fine-time bin at which the test pulse fires |
| out_ready | input | 1 | Consumer accepts the current word |
| out_valid | output | 1 | A readout word is presented |
| out_data | output | 32 | Readout word |

## Verification
A fine count that fails to restart or to saturate shows up as a fine-time field shifted in every word of the next crossing. It appears one strobe after the fault. A channel latch that re-arms or misses a clear gives a wrong bin or an extra word for that channel number alone. A corrupted pending mask in the readout shows at once, as out-of-order channel numbers, repeated channel numbers or a missing final drop of out_valid. The crossing counter and the test-pulse comparator are checked through the word header and through the injected bins that appear at the ports.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;

    localparam int DEF_NUM_CH   = 32;
    localparam int DEF_NUM_BINS = 64;
    localparam int DEF_XING_W   = 8;

    // Readout word, most significant field first
    typedef struct packed {
        logic [7:0] xing;
        logic [2:0] pad_hi;
        logic [4:0] chan;
        logic       valid;
        logic [8:0] pad_lo;
        logic [5:0] bin;
    } tdc_word_t;

    function automatic tdc_word_t make_word(input logic [7:0] xing,
                                            input logic [4:0] chan,
                                            input logic       valid,
                                            input logic [5:0] bin);
        tdc_word_t w;
        w        = '0;
        w.xing   = xing;
        w.chan   = chan;
        w.valid  = valid;
        w.bin    = bin;
        return w;
    endfunction

endpackage

// File: rtl/tdc_timebase.sv
`timescale 1ns/1ps
module tdc_timebase #(
    parameter int NUM_BINS = 64,
    parameter int XING_W   = 8,
    localparam int FINE_W  = $clog2(NUM_BINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bx_strobe,
    output logic              xing_edge,
    output logic              xing_load,
    output logic [FINE_W-1:0] fine_cnt,
    output logic [XING_W-1:0] xing_cnt
);
    localparam logic [FINE_W-1:0] FINE_MAX = FINE_W'(NUM_BINS - 1);

    logic bx_q;
    logic started_q;

    assign xing_edge = bx_strobe & ~bx_q;
    assign xing_load = xing_edge & started_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bx_q      <= 1'b0;
            started_q <= 1'b0;
            fine_cnt  <= '0;
            xing_cnt  <= '0;
        end else begin
            bx_q <= bx_strobe;
            if (xing_edge) begin
                fine_cnt  <= '0;
                started_q <= 1'b1;
                if (started_q)
                    xing_cnt <= xing_cnt + XING_W'(1);
            end else if (fine_cnt != FINE_MAX) begin
                fine_cnt <= fine_cnt + FINE_W'(1);
            end
        end
    end
endmodule

// File: rtl/tdc_channel.sv
`timescale 1ns/1ps
module tdc_channel #(
    parameter int FINE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              hit,
    input  logic [FINE_W-1:0] fine,
    output logic              hit_seen,
    output logic [FINE_W-1:0] bin_out
);
    logic              hit_q;
    logic              seen_q;
    logic [FINE_W-1:0] bin_q;
    logic              rise;

    assign rise = hit & ~hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q  <= 1'b0;
            seen_q <= 1'b0;
            bin_q  <= '0;
        end else begin
            hit_q <= hit;
            if (restart) begin
                seen_q <= 1'b0;
            end else if (rise && !seen_q) begin
                seen_q <= 1'b1;
                bin_q  <= fine;
            end
        end
    end

    assign hit_seen = seen_q;
    assign bin_out  = seen_q ? bin_q : '1;
endmodule

// File: rtl/tdc_testpulse.sv
`timescale 1ns/1ps
module tdc_testpulse #(
    parameter int NUM_CH = 32,
    parameter int FINE_W = 6
) (
    input  logic              tp_enable,
    input  logic [NUM_CH-1:0] tp_mask,
    input  logic [FINE_W-1:0] tp_offset,
    input  logic [FINE_W-1:0] fine,
    output logic [NUM_CH-1:0] tp_pulse
);
    logic fire;

    assign fire     = tp_enable && (fine == tp_offset);
    assign tp_pulse = fire ? tp_mask : '0;
endmodule

// File: rtl/tdc_readout.sv
`timescale 1ns/1ps
module tdc_readout
    import tdc_pkg::*;
#(
    parameter int NUM_CH   = 32,
    parameter int FINE_W   = 6,
    parameter int XING_W   = 8,
    localparam int IDX_W   = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [NUM_CH-1:0]        load_pend,
    input  logic [NUM_CH-1:0]        load_vld,
    input  logic [NUM_CH*FINE_W-1:0] load_bins,
    input  logic [XING_W-1:0]        load_xing,
    input  logic                     out_ready,
    output logic                     out_valid,
    output logic [31:0]              out_data
);
    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] vld_q;
    logic [FINE_W-1:0] bin_q [NUM_CH];
    logic [XING_W-1:0] xing_q;
    logic [IDX_W-1:0]  sel;
    tdc_word_t         word;

    // Lowest pending channel wins
    always_comb begin
        sel = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pend_q[i])
                sel = IDX_W'(i);
        end
    end

    assign out_valid = |pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            vld_q  <= '0;
            xing_q <= '0;
            for (int i = 0; i < NUM_CH; i++)
                bin_q[i] <= '0;
        end else if (load) begin
            pend_q <= load_pend;
            vld_q  <= load_vld;
            xing_q <= load_xing;
            for (int i = 0; i < NUM_CH; i++)
                bin_q[i] <= load_bins[i*FINE_W +: FINE_W];
        end else if (out_valid && out_ready) begin
            pend_q[sel] <= 1'b0;
        end
    end

    assign word     = make_word(8'(xing_q), 5'(sel), vld_q[sel], 6'(bin_q[sel]));
    assign out_data = word;
endmodule

// File: rtl/tdc_array.sv
`timescale 1ns/1ps
module tdc_array
    import tdc_pkg::*;
#(
    parameter int NUM_CH   = DEF_NUM_CH,
    parameter int NUM_BINS = DEF_NUM_BINS,
    parameter int XING_W   = DEF_XING_W,
    localparam int FINE_W  = $clog2(NUM_BINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bx_strobe,
    input  logic [NUM_CH-1:0] hit_in,
    input  logic              emit_empty,
    input  logic              tp_enable,
    input  logic [NUM_CH-1:0] tp_mask,
    input  logic [FINE_W-1:0] tp_offset,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [31:0]       out_data
);
    logic                     xing_edge;
    logic                     xing_load;
    logic [FINE_W-1:0]        fine_cnt;
    logic [XING_W-1:0]        xing_cnt;
    logic [NUM_CH-1:0]        tp_pulse;
    logic [NUM_CH-1:0]        seen_vec;
    logic [NUM_CH*FINE_W-1:0] bin_flat;
    logic [NUM_CH-1:0]        pend_next;

    tdc_timebase #(.NUM_BINS(NUM_BINS), .XING_W(XING_W)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .bx_strobe(bx_strobe),
        .xing_edge(xing_edge),
        .xing_load(xing_load),
        .fine_cnt (fine_cnt),
        .xing_cnt (xing_cnt)
    );

    tdc_testpulse #(.NUM_CH(NUM_CH), .FINE_W(FINE_W)) u_tp (
        .tp_enable(tp_enable),
        .tp_mask  (tp_mask),
        .tp_offset(tp_offset),
        .fine     (fine_cnt),
        .tp_pulse (tp_pulse)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tdc_channel #(.FINE_W(FINE_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .restart (xing_edge),
            .hit     (hit_in[g] | tp_pulse[g]),
            .fine    (fine_cnt),
            .hit_seen(seen_vec[g]),
            .bin_out (bin_flat[g*FINE_W +: FINE_W])
        );
    end

    assign pend_next = emit_empty ? '1 : seen_vec;

    tdc_readout #(.NUM_CH(NUM_CH), .FINE_W(FINE_W), .XING_W(XING_W)) u_ro (
        .clk      (clk),
        .rst      (rst),
        .load     (xing_load),
        .load_pend(pend_next),
        .load_vld (seen_vec),
        .load_bins(bin_flat),
        .load_xing(xing_cnt),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .out_data (out_data)
    );
endmodule

// File: rtl/tdc_array_chk.sv
`timescale 1ns/1ps
module tdc_array_chk #(
    parameter int FINE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              xing_edge,
    input logic              xing_load,
    input logic [FINE_W-1:0] fine,
    input logic              out_valid,
    input logic              out_ready,
    input logic [31:0]       out_data
);
    localparam logic [FINE_W-1:0] FMAX = '1;

    assert_restart_R1: assert property (@(posedge clk) disable iff (rst)
        xing_edge |=> (fine == '0))
        else $error("fine count not restarted");

    assert_advance_R1: assert property (@(posedge clk) disable iff (rst)
        (!xing_edge && fine != FMAX) |=> (fine == $past(fine) + FINE_W'(1)))
        else $error("fine count did not advance");

    assert_saturate_R11: assert property (@(posedge clk) disable iff (rst)
        (!xing_edge && fine == FMAX) |=> (fine == FMAX))
        else $error("fine count left saturation");

    assert_pad_zero_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[23:21] == 3'b0 && out_data[14:6] == 9'b0))
        else $error("reserved word bits set");

    assert_empty_ones_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_data[15]) |-> (out_data[5:0] == 6'h3f))
        else $error("empty channel without all-ones time");

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !xing_load) |=> (out_valid && $stable(out_data)))
        else $error("word changed under back-pressure");

    assert_ascending_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !xing_load) |=>
            (!out_valid || (out_data[20:16] > $past(out_data[20:16]))))
        else $error("channel order not ascending");
endmodule

bind tdc_array tdc_array_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .xing_edge(xing_edge),
    .xing_load(xing_load),
    .fine     (fine_cnt),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
);

// File: tb/tdc_array_test.sv
`timescale 1ns/1ps
module tdc_array_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        bx_strobe;
    logic [31:0] hit_in;
    logic        emit_empty;
    logic        tp_enable;
    logic [31:0] tp_mask;
    logic [5:0]  tp_offset;
    logic        out_ready;
    logic        out_valid;
    logic [31:0] out_data;

    always #5 clk = ~clk;

    tdc_array uut (
        .clk(clk), .rst(rst), .bx_strobe(bx_strobe), .hit_in(hit_in),
        .emit_empty(emit_empty), .tp_enable(tp_enable), .tp_mask(tp_mask),
        .tp_offset(tp_offset), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int strobes = 0;
    int ext_bin [32];
    bit dbl     [32];
    int exp_bin [32];
    logic [31:0] hold_mask = '0;
    bit done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic strobe();
        bx_strobe = 1'b1;
        @(negedge clk);
        bx_strobe = 1'b0;
        strobes++;
    endtask

    task automatic clear_plan();
        for (int c = 0; c < 32; c++) begin
            ext_bin[c] = -1;
            dbl[c]     = 1'b0;
            exp_bin[c] = -1;
        end
        hold_mask = '0;
    endtask

    task automatic plan_ext(input int c, input int b, input bit d);
        ext_bin[c] = b;
        dbl[c]     = d;
        exp_bin[c] = (b > 63) ? 63 : b;
    endtask

    task automatic run_crossing(input int len);
        for (int j = 1; j <= len; j++) begin
            logic [31:0] hv;
            hv = '0;
            for (int c = 0; c < 32; c++) begin
                int b;
                int t;
                b = ext_bin[c];
                t = j - 1;
                if (b >= 0 && ((t >= b && t <= b + 2) || (dbl[c] && t >= b + 5 && t <= b + 6)))
                    hv[c] = 1'b1;
            end
            hit_in = hv | hold_mask;
            @(negedge clk);
        end
        hit_in = '0;
    endtask

    task automatic drain(input int xnum, input bit all, input int stall, input string req);
        for (int c = 0; c < 32; c++) begin
            if (exp_bin[c] >= 0 || all) begin
                logic [31:0] w;
                logic        v;
                logic [5:0]  b6;
                logic [7:0]  x8;
                logic [4:0]  c5;
                v  = (exp_bin[c] >= 0);
                b6 = v ? 6'(exp_bin[c]) : 6'h3f;
                x8 = 8'(xnum);
                c5 = 5'(c);
                w  = {x8, 3'b000, c5, v, 9'b0, b6};
                for (int s = 0; s < stall; s++) begin
                    chk({req, " R6 hold valid"}, {31'b0, out_valid}, 32'd1);
                    chk({req, " R6 hold data"}, out_data, w);
                    @(negedge clk);
                end
                chk({req, " valid"}, {31'b0, out_valid}, 32'd1);
                chk({req, " word"}, out_data, w);
                out_ready = 1'b1;
                @(negedge clk);
                out_ready = 1'b0;
            end
        end
        chk({req, " R5 drained"}, {31'b0, out_valid}, 32'd0);
    endtask

    task automatic full_test(input int len, input bit all, input int stall,
                             input bit tpe, input logic [31:0] tpm, input logic [5:0] tpo,
                             input string req);
        int xa;
        strobe();
        xa = (strobes - 1) & 255;
        tp_enable = tpe;
        tp_mask   = tpm;
        tp_offset = tpo;
        run_crossing(len);
        emit_empty = all;
        strobe();
        emit_empty = 1'b0;
        tp_enable  = 1'b0;
        drain(xa, all, stall, req);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bx_strobe = 1'b0; hit_in = '0; emit_empty = 1'b0;
        tp_enable = 1'b0; tp_mask = '0; tp_offset = '0; out_ready = 1'b0;
        clear_plan();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R5 reset valid", {31'b0, out_valid}, 32'd0);
        chk("R4 reset data", out_data, 32'd0);

        // R8: first strobe closes nothing even in emit-all mode
        hit_in[3] = 1'b1;
        @(negedge clk);
        hit_in = '0;
        @(negedge clk);
        emit_empty = 1'b1;
        strobe();
        emit_empty = 1'b0;
        chk("R8 first strobe silent", {31'b0, out_valid}, 32'd0);
        repeat (5) @(negedge clk);
        strobe();
        chk("R8 empty crossing 0", {31'b0, out_valid}, 32'd0);
        @(negedge clk);

        // R1 R2 R3 R4 R5 R6: sweep with gaps, double pulses and stalls
        for (int r = 0; r < 4; r++) begin
            clear_plan();
            for (int c = 0; c < 32; c++)
                if (c % 5 != r) plan_ext(c, (c * 7 + r * 13) % 61, (c % 3) == 0);
            full_test(70, 1'b0, r, 1'b0, '0, '0, "R1,R2,R3,R4,R5 sweep");
        end

        // R1: every bin 0..63 reached
        for (int k = 0; k < 2; k++) begin
            clear_plan();
            for (int c = 0; c < 32; c++) plan_ext(c, c + 32 * k, 1'(c));
            full_test(70, 1'b0, 0, 1'b0, '0, '0, "R1 bin sweep");
        end

        // R11: saturation at the end of a long crossing
        clear_plan();
        for (int c = 0; c < 16; c++) plan_ext(c, 58 + 2 * c, 1'b0);
        full_test(100, 1'b0, 0, 1'b0, '0, '0, "R11 saturate");

        // R7: emit every channel
        clear_plan();
        for (int c = 0; c < 32; c += 2) plan_ext(c, (c * 3) % 50, 1'b0);
        full_test(64, 1'b1, 1, 1'b0, '0, '0, "R7 emit all");

        // R9: test pulse at several offsets and masks
        begin
            logic [31:0] masks [3];
            logic [5:0]  offs  [3];
            masks[0] = 32'hFFFF_FFFF; offs[0] = 6'd0;
            masks[1] = 32'hA5A5_0F0F; offs[1] = 6'd17;
            masks[2] = 32'h8000_0001; offs[2] = 6'd63;
            for (int t = 0; t < 3; t++) begin
                clear_plan();
                for (int c = 0; c < 32; c++)
                    if (masks[t][c]) exp_bin[c] = int'(offs[t]);
                full_test(70, 1'b0, 0, 1'b1, masks[t], offs[t], "R9 test pulse");
            end
        end

        // R9 R3: an earlier external hit wins over the test pulse
        clear_plan();
        plan_ext(0, 5, 1'b0);
        plan_ext(9, 30, 1'b0);
        for (int c = 1; c < 8; c++) exp_bin[c] = 20;
        full_test(70, 1'b0, 0, 1'b1, 32'h0000_00FF, 6'd20, "R9,R3 mixed");

        // R10: hit coincident with the strobe edge is dropped
        begin
            int xa;
            clear_plan();
            plan_ext(5, 10, 1'b0);
            hold_mask = 32'h0000_0010;
            hit_in    = hold_mask;
            strobe();
            xa = (strobes - 1) & 255;
            run_crossing(64);
            strobe();
            drain(xa, 1'b0, 0, "R10 coincident");
        end

        // R10: unread words discarded by the next crossing
        clear_plan();
        plan_ext(1, 4, 1'b0);
        plan_ext(2, 9, 1'b0);
        strobe();
        run_crossing(64);
        strobe();
        chk("R10 first word chan", {27'b0, out_data[20:16]}, 32'd1);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R10 second pending", {31'b0, out_valid}, 32'd1);
        strobe();
        chk("R10 discarded", {31'b0, out_valid}, 32'd0);
        @(negedge clk);

        // R8: crossing number wraps modulo 256
        repeat (250) begin
            strobe();
            @(negedge clk);
        end
        clear_plan();
        plan_ext(7, 12, 1'b0);
        full_test(64, 1'b0, 0, 1'b0, '0, '0, "R8 wrap");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule